// File: doc/BRIEF.md
# Extended-Operation Trap Context Sequencer

This block performs the context switch for an extended operation, a trap that can be numbered 0 to 15. When a request arrives, the block captures the trap number, the operand's effective address and the caller's workspace pointer, program counter and status word. A routing bit in the caller's status decides which path the request takes. On the hardware path, the request is passed to an external coprocessor through a request/acknowledge handshake. On the software path, the block runs a fixed series of memory transactions.

On the software path, the block first fetches a two-word vector from a table. That table sits in the sixteen word pairs directly above the interrupt vectors. The block then stores the caller's context and the operand address into the workspace named by the vector. Finally it presents the new context for loading, with an active flag set in the new status. For the whole software sequence the block asks the address mapper to use map set 0.

The block is used beside an instruction decoder. The decoder raises `req_valid` for one cycle and then waits for `done`. Decoding the instruction is not part of this block.

Top module: `xop_trap_seq`

## Requirements
- R1: After reset the block is idle: `mem_req`, `hw_req`, `done`, `ctx_load` and `map_zero` are all low.
- R2: If bit 7 of `cur_st` is 1 when a request is accepted, `hw_req` rises with `hw_num` and `hw_ea` equal to the captured number and address. Both are held unchanged until `hw_ack` is seen. No memory access is made. `done` is high in the cycle after the acknowledge, with `ctx_load` low.
- R3: If bit 7 is 0, the first two memory transactions are reads. The first reads the new workspace pointer at 16'h0040 + 4 × number. The second reads the new program counter at that address + 2.
- R4: Four writes follow the reads, in this order, each at vector WP + 2 × register index. Register 11 receives the effective address. Register 13 receives the old WP, register 14 the old PC and register 15 the old status.
- R5: In the cycle after the last write completes, `done` and `ctx_load` are both high. `new_wp` and `new_pc` equal the two vector words. `new_st` equals the captured status with bit 6 set.
- R6: A memory request waits for `mem_rdy`. Until it is accepted, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.
- R7: `map_zero` is high during every memory transaction that the block issues.
- R8: `req_valid` and changes on `req_*`/`cur_*` have no effect while a sequence is in progress. The outcome uses only the values captured at acceptance, and no further sequence starts afterwards.
- R9: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Trap request, sampled while idle |
| req_num | input | 4 | Trap number |
| req_ea | input | 16 | Operand effective address |
| cur_wp | input | 16 | Caller workspace pointer |
| cur_pc | input | 16 | Caller program counter |
| cur_st | input | 16 | Caller status; bit 7 selects the hardware path |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, taken on the ready cycle |
| mem_rdy | input | 1 | Memory accepts the current transaction |
| map_zero | output | 1 | Force address map set 0 |
| hw_req | output | 1 | Hardware coprocessor request |
| hw_num | output | 4 | Trap number for the coprocessor |
| hw_ea | output | 16 | Effective address for the coprocessor |
| hw_ack | input | 1 | Coprocessor acknowledge |
| done | output | 1 | Trap handling finished |
| ctx_load | output | 1 | Load `new_wp`, `new_pc` and `new_st` |
| new_wp | output | 16 | New workspace pointer |
| new_pc | output | 16 | New program counter |
| new_st | output | 16 | New status word with bit 6 set |

## Verification
The embedded properties rely on two input rules. The memory does not pull back a transaction it has not yet accepted. The coprocessor acknowledges only while `hw_req` is high. The bench drives `mem_rdy` and `hw_ack` only from the bench's own view of the pending request, so it stays within these rules, and it varies the readiness pattern among always-ready, random and long-stall modes. Requests are issued only while the block is idle. The one exception is a deliberate stray request, together with scrambled caller inputs, one cycle into each sequence; this exercises the ignore rule.

// File: rtl/xop_pkg.sv
package xop_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VEC_WP,
        ST_VEC_PC,
        ST_SAVE_EA,
        ST_SAVE_WP,
        ST_SAVE_PC,
        ST_SAVE_ST,
        ST_LOAD,
        ST_HW_WAIT,
        ST_HW_DONE
    } seq_state_t;

endpackage

// File: rtl/xop_access_gen.sv
module xop_access_gen
    import xop_pkg::*;
#(
    parameter int                 AW       = 16,
    parameter int                 NUM_W    = 4,
    parameter logic [AW-1:0]      VEC_BASE = 16'h0040,
    parameter int                 EA_REG   = 11,
    parameter int                 WP_REG   = 13,
    parameter int                 PC_REG   = 14,
    parameter int                 ST_REG   = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  seq_state_t         state,
    input  logic [NUM_W-1:0]   num,
    input  logic [AW-1:0]      vec_wp,
    input  logic [AW-1:0]      save_ea,
    input  logic [AW-1:0]      save_wp,
    input  logic [AW-1:0]      save_pc,
    input  logic [AW-1:0]      save_st,
    output logic               access,
    output logic               write,
    output logic [AW-1:0]      addr,
    output logic [AW-1:0]      wdata
);
    localparam int            WORD_BYTES = 2;
    localparam int            PAD_W      = AW - NUM_W - 2;
    localparam logic [AW-1:0] OFF_EA     = AW'(WORD_BYTES * EA_REG);
    localparam logic [AW-1:0] OFF_WP     = AW'(WORD_BYTES * WP_REG);
    localparam logic [AW-1:0] OFF_PC     = AW'(WORD_BYTES * PC_REG);
    localparam logic [AW-1:0] OFF_ST     = AW'(WORD_BYTES * ST_REG);
    localparam logic [AW-1:0] OFF_WORD   = AW'(WORD_BYTES);

    logic [AW-1:0] vec_addr;

    // each vector is a word pair, so the table stride is four bytes
    assign vec_addr = VEC_BASE + {{PAD_W{1'b0}}, num, 2'b00};

    always_comb begin
        access = 1'b1;
        write  = 1'b1;
        addr   = '0;
        wdata  = '0;
        unique case (state)
            ST_VEC_WP:  begin write = 1'b0; addr = vec_addr;            end
            ST_VEC_PC:  begin write = 1'b0; addr = vec_addr + OFF_WORD; end
            ST_SAVE_EA: begin addr = vec_wp + OFF_EA; wdata = save_ea;  end
            ST_SAVE_WP: begin addr = vec_wp + OFF_WP; wdata = save_wp;  end
            ST_SAVE_PC: begin addr = vec_wp + OFF_PC; wdata = save_pc;  end
            ST_SAVE_ST: begin addr = vec_wp + OFF_ST; wdata = save_st;  end
            default:    begin access = 1'b0; write = 1'b0;              end
        endcase
    end

    // R4: a write is only ever issued as part of a memory transaction
    assert_write_in_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        write |-> access);

    // R3: the vector read addresses stay inside the vector table
    assert_vec_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !write) |-> (addr >= VEC_BASE));

endmodule

// File: rtl/xop_status_ctl.sv
module xop_status_ctl #(
    parameter int AW      = 16,
    parameter int ACT_BIT = 6
) (
    input  logic          route_bit,
    input  logic [AW-1:0] saved_st,
    output logic          hw_sel,
    output logic [AW-1:0] next_st
);
    always_comb begin
        hw_sel           = route_bit;
        next_st          = saved_st;
        next_st[ACT_BIT] = 1'b1;
    end
endmodule

// File: rtl/xop_trap_seq.sv
module xop_trap_seq
    import xop_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            NUM_W    = 4,
    parameter logic [AW-1:0] VEC_BASE = 16'h0040,
    parameter int            HW_BIT   = 7,
    parameter int            ACT_BIT  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [NUM_W-1:0] req_num,
    input  logic [AW-1:0]    req_ea,
    input  logic [AW-1:0]    cur_wp,
    input  logic [AW-1:0]    cur_pc,
    input  logic [AW-1:0]    cur_st,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [AW-1:0]    mem_wdata,
    input  logic [AW-1:0]    mem_rdata,
    input  logic             mem_rdy,
    output logic             map_zero,
    output logic             hw_req,
    output logic [NUM_W-1:0] hw_num,
    output logic [AW-1:0]    hw_ea,
    input  logic             hw_ack,
    output logic             done,
    output logic             ctx_load,
    output logic [AW-1:0]    new_wp,
    output logic [AW-1:0]    new_pc,
    output logic [AW-1:0]    new_st
);
    typedef struct packed {
        seq_state_t       state;
        logic [NUM_W-1:0] num;
        logic [AW-1:0]    ea;
        logic [AW-1:0]    wp;
        logic [AW-1:0]    pc;
        logic [AW-1:0]    st;
        logic [AW-1:0]    vwp;
        logic [AW-1:0]    vpc;
    } seq_t;

    seq_t seq_d, seq_q;
    logic route_hw;

    xop_status_ctl #(.AW(AW), .ACT_BIT(ACT_BIT)) u_status (
        .route_bit (cur_st[HW_BIT]),
        .saved_st  (seq_q.st),
        .hw_sel    (route_hw),
        .next_st   (new_st)
    );

    xop_access_gen #(.AW(AW), .NUM_W(NUM_W), .VEC_BASE(VEC_BASE)) u_access (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (seq_q.state),
        .num     (seq_q.num),
        .vec_wp  (seq_q.vwp),
        .save_ea (seq_q.ea),
        .save_wp (seq_q.wp),
        .save_pc (seq_q.pc),
        .save_st (seq_q.st),
        .access  (mem_req),
        .write   (mem_we),
        .addr    (mem_addr),
        .wdata   (mem_wdata)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_IDLE: if (req_valid) begin
                seq_d.num   = req_num;
                seq_d.ea    = req_ea;
                seq_d.wp    = cur_wp;
                seq_d.pc    = cur_pc;
                seq_d.st    = cur_st;
                seq_d.state = route_hw ? ST_HW_WAIT : ST_VEC_WP;
            end
            ST_VEC_WP: if (mem_rdy) begin
                seq_d.vwp   = mem_rdata;
                seq_d.state = ST_VEC_PC;
            end
            ST_VEC_PC: if (mem_rdy) begin
                seq_d.vpc   = mem_rdata;
                seq_d.state = ST_SAVE_EA;
            end
            ST_SAVE_EA: if (mem_rdy) seq_d.state = ST_SAVE_WP;
            ST_SAVE_WP: if (mem_rdy) seq_d.state = ST_SAVE_PC;
            ST_SAVE_PC: if (mem_rdy) seq_d.state = ST_SAVE_ST;
            ST_SAVE_ST: if (mem_rdy) seq_d.state = ST_LOAD;
            ST_HW_WAIT: if (hw_ack)  seq_d.state = ST_HW_DONE;
            default:                 seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign map_zero = (seq_q.state != ST_IDLE) && (seq_q.state != ST_HW_WAIT)
                   && (seq_q.state != ST_HW_DONE);
    assign hw_req   = (seq_q.state == ST_HW_WAIT);
    assign hw_num   = seq_q.num;
    assign hw_ea    = seq_q.ea;
    assign done     = (seq_q.state == ST_LOAD) || (seq_q.state == ST_HW_DONE);
    assign ctx_load = (seq_q.state == ST_LOAD);
    assign new_wp   = seq_q.vwp;
    assign new_pc   = seq_q.vpc;

    assert_mem_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    assert_hw_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_req && !hw_ack) |=> (hw_req && $stable(hw_num) && $stable(hw_ea)));

    assert_hw_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hw_req |-> !mem_req);

    assert_hw_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_req && hw_ack) |=> (done && !ctx_load));

    assert_map_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> map_zero);

    assert_load_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_load |-> (done && new_st[ACT_BIT]));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_single_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, hw_req, done}));

endmodule

// File: tb/tb_xop_trap_seq.sv
`timescale 1ns/1ps
module tb_xop_trap_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_num = '0;
    logic [15:0] req_ea = '0, cur_wp = '0, cur_pc = '0, cur_st = '0;
    logic        mem_req, mem_we, map_zero, hw_req, done, ctx_load;
    logic [15:0] mem_addr, mem_wdata, hw_ea, new_wp, new_pc, new_st;
    logic [15:0] mem_rdata = '0;
    logic        mem_rdy = 1'b0, hw_ack = 1'b0;
    logic [3:0]  hw_num;

    int checks = 0, fails = 0;
    int rdy_mode = 0, stall_cnt = 0;
    int nlog = 0;
    logic [15:0] log_addr [16];
    logic [15:0] log_data [16];
    logic        log_we   [16];
    logic        pend = 1'b0, pend_we = 1'b0;
    logic [15:0] pend_addr = '0, pend_wdata = '0;
    logic        done_seen = 1'b0, prev_done = 1'b0, cap_load = 1'b0;
    logic [15:0] cap_wp = '0, cap_pc = '0, cap_st = '0;
    logic        hw_seen = 1'b0, hw_bad = 1'b0;
    logic [3:0]  exp_num = '0;
    logic [15:0] exp_ea = '0;

    always #4 clk = ~clk;

    xop_trap_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_num(req_num),
        .req_ea(req_ea), .cur_wp(cur_wp), .cur_pc(cur_pc), .cur_st(cur_st),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .map_zero(map_zero), .hw_req(hw_req), .hw_num(hw_num), .hw_ea(hw_ea),
        .hw_ack(hw_ack), .done(done), .ctx_load(ctx_load), .new_wp(new_wp),
        .new_pc(new_pc), .new_st(new_st)
    );

    function automatic logic [15:0] mem_val(input logic [15:0] a);
        return ((a * 16'd37) ^ 16'h9A40) & 16'hFFFE;
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory, coprocessor and completion monitor, all at the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rdy = 1'b0; hw_ack = 1'b0; pend = 1'b0; prev_done = 1'b0;
        end else begin
            if (pend)
                chk(mem_req && mem_addr == pend_addr && mem_we == pend_we
                    && mem_wdata == pend_wdata, "R6", "request held while waiting",
                    {15'd0, mem_req, mem_addr}, {15'd0, 1'b1, pend_addr});
            case (rdy_mode)
                1:       mem_rdy = 1'b1;
                2:       begin stall_cnt++; mem_rdy = (stall_cnt % 6 == 0); end
                default: mem_rdy = ($urandom % 3) != 0;
            endcase
            if (mem_req && mem_rdy) begin
                chk(map_zero, "R7", "map set 0 during access", {31'd0, map_zero}, 32'd1);
                if (nlog < 16) begin
                    log_addr[nlog] = mem_addr; log_data[nlog] = mem_wdata;
                    log_we[nlog] = mem_we;
                end
                nlog++;
                mem_rdata = mem_we ? 16'hDEAD : mem_val(mem_addr);
                pend = 1'b0;
            end else begin
                pend = mem_req; pend_addr = mem_addr; pend_we = mem_we;
                pend_wdata = mem_wdata;
            end
            if (hw_req) begin
                hw_seen = 1'b1;
                if (hw_num != exp_num || hw_ea != exp_ea) hw_bad = 1'b1;
                hw_ack = (rdy_mode == 1) ? 1'b1 : (($urandom % 2) != 0);
            end else begin
                hw_ack = 1'b0;
            end
            if (done) begin
                chk(!prev_done, "R9", "done is one cycle", {31'd0, prev_done}, 32'd0);
                done_seen = 1'b1; cap_load = ctx_load;
                cap_wp = new_wp; cap_pc = new_pc; cap_st = new_st;
            end
            prev_done = done;
        end
    end

    task automatic run_xop(input logic [3:0] n, input logic [15:0] ea,
                           input logic [15:0] wp, input logic [15:0] pc,
                           input logic [15:0] st);
        logic [15:0] va, vwp;
        logic [15:0] e_addr [6];
        logic [15:0] e_data [6];
        int waited;
        @(negedge clk);
        nlog = 0; done_seen = 1'b0; hw_seen = 1'b0; hw_bad = 1'b0;
        exp_num = n; exp_ea = ea;
        req_valid = 1'b1; req_num = n; req_ea = ea;
        cur_wp = wp; cur_pc = pc; cur_st = st;
        @(negedge clk);
        // R8: stray request with scrambled inputs while busy
        req_num = ~n; req_ea = ~ea; cur_wp = ~wp; cur_pc = ~pc; cur_st = st ^ 16'h00C0;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        while (!done_seen && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        chk(done_seen, "R9", "done reached", {31'd0, done_seen}, 32'd1);
        if (st[7]) begin
            chk(nlog == 0, "R2", "no memory access on hardware path", nlog, 0);
            chk(hw_seen && !hw_bad, "R2", "hw request fields",
                {12'd0, hw_num, hw_ea}, {12'd0, n, ea});
            chk(!cap_load, "R2", "no context load on hardware path", {31'd0, cap_load}, 0);
        end else begin
            va  = 16'h0040 + {10'd0, n, 2'b00};
            vwp = mem_val(va);
            e_addr[0] = va;          e_data[0] = 16'h0000;
            e_addr[1] = va + 16'd2;  e_data[1] = 16'h0000;
            e_addr[2] = vwp + 16'd22; e_data[2] = ea;
            e_addr[3] = vwp + 16'd26; e_data[3] = wp;
            e_addr[4] = vwp + 16'd28; e_data[4] = pc;
            e_addr[5] = vwp + 16'd30; e_data[5] = st;
            chk(nlog == 6, "R3", "six memory transactions", nlog, 6);
            for (int i = 0; i < 6; i++) begin
                if (i < 2)
                    chk(log_addr[i] == e_addr[i] && !log_we[i], "R3", "vector read",
                        {15'd0, log_we[i], log_addr[i]}, {16'd0, e_addr[i]});
                else
                    chk(log_addr[i] == e_addr[i] && log_we[i] && log_data[i] == e_data[i],
                        "R4", "context save", {log_addr[i], log_data[i]},
                        {e_addr[i], e_data[i]});
            end
            chk(cap_load, "R5", "context load with done", {31'd0, cap_load}, 32'd1);
            chk(cap_wp == vwp && cap_pc == mem_val(va + 16'd2), "R5", "new wp/pc",
                {cap_wp, cap_pc}, {vwp, mem_val(va + 16'd2)});
            chk(cap_st == (st | 16'h0040), "R5", "new status", {16'd0, cap_st},
                {16'd0, st | 16'h0040});
        end
        @(negedge clk);
        @(negedge clk);
        chk(!mem_req && !hw_req && !done, "R8", "no extra sequence",
            {29'd0, mem_req, hw_req, done}, 32'd0);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!mem_req && !hw_req && !done && !ctx_load && !map_zero, "R1", "reset state",
            {27'd0, mem_req, hw_req, done, ctx_load, map_zero}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && !hw_req && !done && !map_zero, "R1", "idle after reset",
            {28'd0, mem_req, hw_req, done, map_zero}, 32'd0);
        // directed corners
        rdy_mode = 1;
        run_xop(4'd0,  16'h1234, 16'h0100, 16'h2000, 16'h0003);
        run_xop(4'd15, 16'hFFFF, 16'hFFFE, 16'h0002, 16'hFF3F);
        run_xop(4'd5,  16'hABCD, 16'h0200, 16'h3000, 16'h0080);
        rdy_mode = 2;
        run_xop(4'd9,  16'h0000, 16'h8000, 16'h7FFE, 16'h0000);
        run_xop(4'd3,  16'h5555, 16'h4000, 16'h1111, 16'h0081);
        // constrained random
        rdy_mode = 0;
        for (int k = 0; k < 40; k++) begin
            logic [15:0] st;
            st = 16'($urandom);
            st[7] = (($urandom % 4) == 0);
            run_xop(4'($urandom), 16'($urandom), 16'($urandom) & 16'hFFFE,
                    16'($urandom) & 16'hFFFE, st);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule